// File: doc/BRIEF.md
# Scanline Interrupt Source Controller

This block raises a single level interrupt request toward a CPU from a video line counter. Two kinds of event drive the same request line: a vertical-blank event on one fixed line of the frame, and a periodic timer tick on every line whose number is a multiple of four. Each event loads a distinct code into an 8-bit source register, so the interrupt handler can tell the causes apart by reading it.

The request is held, not pulsed. It stays asserted until the CPU writes zero to the source register at bus address 0xFF04, which the handler does as its last step. The video timing generator supplies a one-cycle line strobe together with the current line number, in a frame of 512 lines numbered 0 to 511. The CPU reaches the register through a plain address, write-data, read-data bus with write and read strobes.

Top module: `scanline_irq_ctrl`

## Requirements
- R1: After reset the request output is 0 and the source register reads 0x00.
- R2: A line strobe with line number 256 sets the request to 1 and the source register to 0x02 on the next clock edge.
- R3: A line strobe with any line number other than 256 whose two low bits are 00 sets the request to 1 and the source register to 0x04 on the next clock edge.
- R4: Line 256 is also a multiple of four; on that line the vblank code 0x02 is loaded, never 0x04.
- R5: A line strobe on a line whose two low bits are not 00 changes neither the request nor the source register.
- R6: Once set, the request stays 1 on every following cycle until a zero write to address 0xFF04 clears it.
- R7: A write of 0x00 to address 0xFF04 clears the request and the source register on the next clock edge.
- R8: A write of a nonzero value to address 0xFF04 loads that value into the source register and leaves the request unchanged.
- R9: Writes to any address other than 0xFF04 change neither the request nor the source register.
- R10: A read strobe at address 0xFF04 returns the source register on the read-data output in the same cycle; any other read, or no read strobe, returns 0x00.
- R11: An event arriving while a request is pending overwrites the source code and keeps the request at 1.
- R12: When an event and a CPU write to 0xFF04 fall in the same cycle, the event wins: the request is 1 and the event's code is loaded.
- R13: The line number is ignored while the line strobe is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_stb | input | 1 | One-cycle strobe marking the start of a video line |
| line_num | input | 9 | Number of the line being started, 0 to 511 |
| cpu_addr | input | 16 | CPU bus address |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, source register when 0xFF04 is read, else 0 |
| irq | output | 1 | Held interrupt request to the CPU |

## Verification
Every one of the 512 line numbers is strobed from an idle, acknowledged state, which separates the vblank line, the three kinds of non-multiple line and the tick lines, and shows that line 256 gets the vblank code rather than the tick code. A second sweep strobes every line while a request is already pending, telling apart an overwrite of the code from a lost or dropped request. Targeted patterns then pit a zero write against an event in the same cycle, nonzero writes against zero writes, the source address against its neighbours, and a changing line number without a strobe.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  localparam int unsigned SRC_W = 8;

  typedef enum logic [SRC_W-1:0] {
    SRC_NONE   = 8'h00,
    SRC_VBLANK = 8'h02,
    SRC_TICK   = 8'h04
  } src_code_e;

endpackage

// File: rtl/sirq_line_decode.sv
module sirq_line_decode #(
  parameter int unsigned LINE_W      = 9,
  parameter int unsigned VBLANK_LINE = 256,
  parameter int unsigned TICK_LOG2   = 2
) (
  input  logic              line_stb,
  input  logic [LINE_W-1:0] line_num,
  output logic              ev_vblank,
  output logic              ev_tick
);

  localparam logic [LINE_W-1:0] VBL_L = LINE_W'(VBLANK_LINE);

  function automatic logic on_tick_grid(input logic [LINE_W-1:0] ln);
    return (ln[TICK_LOG2-1:0] == '0);
  endfunction

  function automatic logic on_vblank(input logic [LINE_W-1:0] ln);
    return (ln == VBL_L);
  endfunction

  // vblank outranks the periodic tick on the shared line
  assign ev_vblank = line_stb && on_vblank(line_num);
  assign ev_tick   = line_stb && on_tick_grid(line_num) && !on_vblank(line_num);

endmodule

// File: rtl/sirq_bus_decode.sv
module sirq_bus_decode #(
  parameter int unsigned       ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] SRC_ADDR = 16'hFF04
) (
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  output logic              wr_hit,
  output logic              rd_hit
);

  logic addr_hit;

  assign addr_hit = (cpu_addr == SRC_ADDR);
  assign wr_hit   = cpu_wr && addr_hit;
  assign rd_hit   = cpu_rd && addr_hit;

endmodule

// File: rtl/sirq_src_reg.sv
module sirq_src_reg
  import sirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_vblank,
  input  logic             ev_tick,
  input  logic             wr_hit,
  input  logic [SRC_W-1:0] wdata,
  output logic [SRC_W-1:0] src_q,
  output logic             irq_q
);

  logic             any_event;
  logic [SRC_W-1:0] event_code;

  assign any_event  = ev_vblank || ev_tick;
  assign event_code = ev_vblank ? SRC_VBLANK : SRC_TICK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= SRC_NONE;
      irq_q <= 1'b0;
    end else if (any_event) begin
      // a hardware event is never lost to a concurrent CPU write
      src_q <= event_code;
      irq_q <= 1'b1;
    end else if (wr_hit) begin
      src_q <= wdata;
      if (wdata == SRC_NONE) irq_q <= 1'b0;
    end
  end

endmodule

// File: rtl/scanline_irq_ctrl.sv
module scanline_irq_ctrl
  import sirq_pkg::*;
#(
  parameter int unsigned       LINE_W      = 9,
  parameter int unsigned       VBLANK_LINE = 256,
  parameter int unsigned       TICK_LOG2   = 2,
  parameter int unsigned       ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] SRC_ADDR    = 16'hFF04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_stb,
  input  logic [LINE_W-1:0] line_num,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [SRC_W-1:0]  cpu_wdata,
  output logic [SRC_W-1:0]  cpu_rdata,
  output logic              irq
);

  logic             ev_vblank;
  logic             ev_tick;
  logic             wr_hit;
  logic             rd_hit;
  logic [SRC_W-1:0] src_q;

  sirq_line_decode #(
    .LINE_W(LINE_W), .VBLANK_LINE(VBLANK_LINE), .TICK_LOG2(TICK_LOG2)
  ) u_line (
    .line_stb(line_stb), .line_num(line_num),
    .ev_vblank(ev_vblank), .ev_tick(ev_tick)
  );

  sirq_bus_decode #(
    .ADDR_W(ADDR_W), .SRC_ADDR(SRC_ADDR)
  ) u_bus (
    .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .wr_hit(wr_hit), .rd_hit(rd_hit)
  );

  sirq_src_reg u_src (
    .clk(clk), .rst_n(rst_n),
    .ev_vblank(ev_vblank), .ev_tick(ev_tick),
    .wr_hit(wr_hit), .wdata(cpu_wdata),
    .src_q(src_q), .irq_q(irq)
  );

  assign cpu_rdata = rd_hit ? src_q : SRC_NONE;

endmodule

// File: rtl/scanline_irq_chk.sv
module scanline_irq_chk #(
  parameter int unsigned       LINE_W      = 9,
  parameter int unsigned       VBLANK_LINE = 256,
  parameter int unsigned       ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] SRC_ADDR    = 16'hFF04
) (
  input logic              clk,
  input logic              rst_n,
  input logic              line_stb,
  input logic [LINE_W-1:0] line_num,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_wr,
  input logic              cpu_rd,
  input logic [7:0]        cpu_wdata,
  input logic [7:0]        cpu_rdata,
  input logic [7:0]        src_q,
  input logic              irq
);

  logic stb_vbl, stb_tick, stb_ev, wr_src, wr_zero;
  assign stb_vbl  = line_stb && (line_num == LINE_W'(VBLANK_LINE));
  assign stb_tick = line_stb && (line_num[1:0] == 2'b00) && !stb_vbl;
  assign stb_ev   = stb_vbl || stb_tick;
  assign wr_src   = cpu_wr && (cpu_addr == SRC_ADDR);
  assign wr_zero  = wr_src && (cpu_wdata == 8'h00);

  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (!irq && src_q == 8'h00));

  a_r2_vblank_code: assert property (@(posedge clk) disable iff (!rst_n)
    stb_vbl |=> (irq && src_q == 8'h02));

  a_r3_tick_code: assert property (@(posedge clk) disable iff (!rst_n)
    stb_tick |=> (irq && src_q == 8'h04));

  a_r6_held: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !wr_zero) |=> irq);

  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_zero && !stb_ev) |=> (!irq && src_q == 8'h00));

  a_r9_quiet_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb_ev && !wr_src) |=> ($stable(irq) && $stable(src_q)));

  a_r10_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_rd && cpu_addr == SRC_ADDR) |-> (cpu_rdata == 8'h00));

endmodule

bind scanline_irq_ctrl scanline_irq_chk #(
  .LINE_W(LINE_W), .VBLANK_LINE(VBLANK_LINE), .ADDR_W(ADDR_W), .SRC_ADDR(SRC_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .line_num(line_num),
  .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
  .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .src_q(src_q), .irq(irq)
);

// File: tb/tb_scanline_irq_ctrl.sv
`timescale 1ns/1ps
module tb_scanline_irq_ctrl;

  localparam logic [15:0] SRC_A = 16'hFF04;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_stb = 1'b0;
  logic [8:0]  line_num = '0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_wr = 1'b0;
  logic        cpu_rd = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  logic       m_irq;
  logic [7:0] m_src;

  always #2 clk = ~clk;

  scanline_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .line_num(line_num),
    .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq)
  );

  function automatic logic [7:0] code_for(input int ln);
    if (ln == 256) return 8'd2;
    if (ln % 4 == 0) return 8'd4;
    return 8'd0;
  endfunction

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic read_src(output logic [7:0] v);
    cpu_addr = SRC_A; cpu_rd = 1'b1;
    #0.5 v = cpu_rdata;
    cpu_rd = 1'b0; cpu_addr = '0;
  endtask

  task automatic check_state(input string tag);
    logic [7:0] v;
    chk({tag, " irq"}, {7'd0, irq}, {7'd0, m_irq});
    read_src(v);
    chk({tag, " src"}, v, m_src);
  endtask

  task automatic strobe(input int ln);
    @(negedge clk);
    line_stb = 1'b1; line_num = 9'(ln);
    @(negedge clk);
    line_stb = 1'b0;
    if (code_for(ln) != 0) begin m_irq = 1'b1; m_src = code_for(ln); end
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wr = 1'b1; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0; cpu_addr = '0;
    if (a == SRC_A) begin
      m_src = d;
      if (d == 0) m_irq = 1'b0;
    end
  endtask

  initial begin
    #(4.0 * 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  initial begin
    logic [7:0] v;
    m_irq = 1'b0; m_src = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1 reset");

    // R2 R3 R4 R5: every line from an idle state
    for (int ln = 0; ln < 512; ln++) begin
      cpu_write(SRC_A, 8'h00);
      chk("R7 ack", {7'd0, irq}, 8'd0);
      strobe(ln);
      if (ln == 256) check_state("R2 R4 vblank line");
      else if (ln % 4 == 0) check_state("R3 tick line");
      else check_state("R5 off-grid line");
    end

    // R11: every line while a request is pending
    cpu_write(SRC_A, 8'h00);
    strobe(256);
    for (int ln = 0; ln < 512; ln++) begin
      strobe(ln);
      check_state("R11 pending overwrite");
    end

    // R6: held over many idle cycles
    repeat (20) @(negedge clk);
    check_state("R6 held");

    // R9: other addresses, including zero data
    cpu_write(16'hFF05, 8'h00);
    cpu_write(16'hFF03, 8'h00);
    cpu_write(16'h7F04, 8'h00);
    check_state("R9 foreign write");

    // R10: reads off the source address
    cpu_addr = 16'hFF05; cpu_rd = 1'b1;
    #0.5 chk("R10 foreign read", cpu_rdata, 8'h00);
    cpu_rd = 1'b0; cpu_addr = SRC_A;
    #0.5 chk("R10 no strobe", cpu_rdata, 8'h00);
    cpu_addr = '0;

    // R8: nonzero write while pending and while idle
    cpu_write(SRC_A, 8'h5A);
    check_state("R8 nonzero pending");
    cpu_write(SRC_A, 8'h00);
    check_state("R7 cleared");
    cpu_write(SRC_A, 8'hA1);
    check_state("R8 nonzero idle");
    cpu_write(SRC_A, 8'h00);

    // R12: event and ack in the same cycle
    @(negedge clk);
    line_stb = 1'b1; line_num = 9'd8;
    cpu_addr = SRC_A; cpu_wr = 1'b1; cpu_wdata = 8'h00;
    @(negedge clk);
    line_stb = 1'b0; cpu_wr = 1'b0; cpu_addr = '0;
    m_irq = 1'b1; m_src = 8'h04;
    check_state("R12 tick beats ack");
    @(negedge clk);
    line_stb = 1'b1; line_num = 9'd256;
    cpu_addr = SRC_A; cpu_wr = 1'b1; cpu_wdata = 8'h77;
    @(negedge clk);
    line_stb = 1'b0; cpu_wr = 1'b0; cpu_addr = '0;
    m_src = 8'h02;
    check_state("R12 vblank beats write");

    // R13: line number moves with no strobe
    cpu_write(SRC_A, 8'h00);
    for (int ln = 252; ln < 260; ln++) begin
      @(negedge clk);
      line_num = 9'(ln);
    end
    @(negedge clk);
    check_state("R13 no strobe");

    read_src(v);
    chk("R1 final idle src", v, 8'h00);
    report();
  end

endmodule